// File: doc/BRIEF.md
# Luma Intra Mode Scheduler with Inter-Cost Early Abort

This controller steps one macroblock through luma intra prediction. After a start pulse it visits the sixteen 4x4 blocks in zig-zag order. For each block it issues the 4x4 prediction modes to the predictor datapath: first the mode that needs no left neighbours, then horizontal, then the other seven. After that comes a best-mode output slot. Reconstruction of a 4x4 block has to finish before the next block can use its pixels. The scheduler fills that wait with two kinds of work: the four 16x16 prediction modes for the matching 4x4 slice of the macroblock, and the next block's vertical mode, which can run ahead.

The controller also sums every intra cost reported by the cost logic. It compares the running total with the best inter cost, which an earlier pipeline stage supplies and which is latched at start. When the total passes that cost, it abandons the macroblock's intra work, raises a skip flag that selects inter coding, and signals done. The DC result of each 16x16 slice is kept in a small register store, so that a later 4x4 Hadamard stage can read all sixteen values per mode.

Top module: `intra_mode_sched`

## Requirements
- R1: After reset `issue_valid_o`, `cat_o`, `skip_o` and `done_o` are all 0, and the block stays idle until `start_i`. Cost inputs seen while idle have no effect on the total.
- R2: Blocks are taken in index order 0..15. `blk_x_o` = {idx[2], idx[0]} and `blk_y_o` = {idx[3], idx[1]}. This is zig-zag order, so two blocks issued one after the other are never vertically adjacent.
- R3: Each block's 4x4 work is issued with `cat_o` = 1, each mode for MODE_CYC cycles, in the mode order 0 (vertical), 1 (horizontal), then 2 to 8. After that comes a best-mode slot with `cat_o` = 3 lasting BEST_CYC cycles.
- R4: After the best-mode slot, the four 16x16 modes 0..3 are issued for the same block index with `cat_o` = 2, each for MODE_CYC cycles.
- R5: For blocks 0..14, the vertical mode (`cat_o` = 1, mode 0) of the next block is issued right after the 16x16 slice, without waiting for reconstruction.
- R6: The next block's horizontal mode, or the end of the macroblock after block 15, comes only once `recon_done_i` has been seen during the 16x16 slice, the early vertical slot or the wait that follows. A pulse seen during the slice or the early vertical slot is remembered. While waiting, `issue_valid_o` is 0, and the wait lasts at least one cycle.
- R7: `done_o` is a one-cycle pulse after block 15 completes reconstruction. With the defaults and `recon_done_i` held high, it rises 912 cycles after the clock edge that accepts `start_i`.
- R8: Every `cost_valid_i` cycle while busy adds `cost_i` to a saturating total. If the new total is strictly greater than the latched inter cost, then at that same edge `skip_o` and `done_o` go to 1 and issuing stops. A total equal to the inter cost does not abort.
- R9: Accepting `start_i` clears the total and `skip_o` and latches `best_inter_i`. Later changes on `best_inter_i` have no effect on that macroblock.
- R10: `start_i` while busy is ignored.
- R11: `skip_o` holds its value from the end of one macroblock until the next start.
- R12: A `dc_valid_i` cycle during a 16x16 slot stores `dc_i` at the issued mode and block. `dc_rd_o` returns the entry addressed by `dc_rd_mode_i` and `dc_rd_blk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a macroblock (taken when idle) |
| best_inter_i | input | COST_W | Best inter cost from the earlier stage |
| cost_valid_i | input | 1 | A cost value is present |
| cost_i | input | COST_W | Intra cost to accumulate |
| recon_done_i | input | 1 | Reconstruction of the current 4x4 block finished |
| dc_valid_i | input | 1 | DC result present for the current 16x16 slot |
| dc_i | input | DC_W | DC result |
| dc_rd_mode_i | input | 2 | DC store read mode |
| dc_rd_blk_i | input | 4 | DC store read block |
| issue_valid_o | output | 1 | A slot is being issued |
| cat_o | output | 2 | 0 none, 1 4x4 mode, 2 16x16 mode, 3 best-mode output |
| mode_o | output | 4 | Prediction mode number |
| blk_o | output | 4 | Block index in processing order |
| blk_x_o | output | 2 | Block column |
| blk_y_o | output | 2 | Block row |
| dc_rd_o | output | DC_W | DC store read data |
| skip_o | output | 1 | Intra abandoned, use inter coding |
| done_o | output | 1 | Macroblock finished (one cycle) |

## Verification
A wrong slot counter or mode register shows up at once on `cat_o`/`mode_o`/`blk_o`. The bench compares these outputs against an independently built schedule on every cycle, so a fault is caught in the cycle it first appears. A bad reconstruction flag either lets the next block's horizontal mode through during a wait, or stalls it after `recon_done_i`; both are seen within one cycle of the event. A wrong accumulator or latched limit moves the abort edge. Cost sequences that land exactly on the limit and one past it pin that edge to a single cycle, and DC-store addressing faults appear on readback after a full macroblock.

// File: rtl/ims_pkg.sv
package ims_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_V4,
        ST_H4,
        ST_NORM,
        ST_BEST,
        ST_SLICE,
        ST_VNEXT,
        ST_WAIT
    } ims_state_e;

    localparam logic [1:0] CAT_NONE = 2'd0;
    localparam logic [1:0] CAT_L4   = 2'd1;
    localparam logic [1:0] CAT_L16  = 2'd2;
    localparam logic [1:0] CAT_BEST = 2'd3;

    localparam int N_BLK   = 16;
    localparam int N_MODE16 = 4;
    localparam int LAST_MODE4 = 8;
endpackage

// File: rtl/ims_blk_pos.sv
module ims_blk_pos (
    input  logic [3:0] idx_i,
    output logic [1:0] x_o,
    output logic [1:0] y_o
);
    // Zig-zag index bits interleave column and row bits.
    assign x_o = {idx_i[2], idx_i[0]};
    assign y_o = {idx_i[3], idx_i[1]};
endmodule

// File: rtl/ims_cost_guard.sv
module ims_cost_guard #(
    parameter int COST_W = 13,
    parameter int ACC_W  = 17
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic              cost_valid_i,
    input  logic [COST_W-1:0] cost_i,
    input  logic [COST_W-1:0] limit_i,
    output logic              over_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] sum_sat;

    always_comb begin
        sum     = {1'b0, acc_q} + (ACC_W+1)'(cost_i);
        sum_sat = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
        over_o  = en_i && cost_valid_i && (sum_sat > ACC_W'(limit_i));
        acc_d   = acc_q;
        if (clear_i) begin
            acc_d = '0;
        end else if (en_i && cost_valid_i) begin
            acc_d = sum_sat;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end
endmodule

// File: rtl/ims_dc_store.sv
module ims_dc_store #(
    parameter int DC_W = 12
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic [1:0]      wr_mode_i,
    input  logic [3:0]      wr_blk_i,
    input  logic [DC_W-1:0] wr_data_i,
    input  logic [1:0]      rd_mode_i,
    input  logic [3:0]      rd_blk_i,
    output logic [DC_W-1:0] rd_data_o
);
    localparam int DEPTH = ims_pkg::N_MODE16 * ims_pkg::N_BLK;

    logic [DC_W-1:0] mem_d [DEPTH];
    logic [DC_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_i) mem_d[{wr_mode_i, wr_blk_i}] = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data_o = mem_q[{rd_mode_i, rd_blk_i}];
endmodule

// File: rtl/intra_mode_sched.sv
module intra_mode_sched #(
    parameter int COST_W   = 13,
    parameter int ACC_W    = 17,
    parameter int DC_W     = 12,
    parameter int MODE_CYC = 4,
    parameter int BEST_CYC = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [COST_W-1:0] best_inter_i,
    input  logic              cost_valid_i,
    input  logic [COST_W-1:0] cost_i,
    input  logic              recon_done_i,
    input  logic              dc_valid_i,
    input  logic [DC_W-1:0]   dc_i,
    input  logic [1:0]        dc_rd_mode_i,
    input  logic [3:0]        dc_rd_blk_i,
    output logic              issue_valid_o,
    output logic [1:0]        cat_o,
    output logic [3:0]        mode_o,
    output logic [3:0]        blk_o,
    output logic [1:0]        blk_x_o,
    output logic [1:0]        blk_y_o,
    output logic [DC_W-1:0]   dc_rd_o,
    output logic              skip_o,
    output logic              done_o
);
    import ims_pkg::*;

    localparam int SLOT_MAX = (MODE_CYC > BEST_CYC) ? MODE_CYC : BEST_CYC;
    localparam int CNT_W    = $clog2(SLOT_MAX + 1);
    localparam logic [3:0] BLK_LAST = 4'(N_BLK - 1);

    typedef struct packed {
        ims_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        mode;
        logic [3:0]        blk;
        logic              seen;
        logic              skip;
        logic              done;
        logic [COST_W-1:0] limit;
    } ims_regs_t;

    ims_regs_t r_d, r_q;

    logic start_ok, busy, over, slot_last;

    assign busy     = (r_q.state != ST_IDLE);
    assign start_ok = start_i && !busy;

    always_comb begin
        if (r_q.state == ST_BEST) slot_last = (r_q.cnt == CNT_W'(BEST_CYC - 1));
        else                      slot_last = (r_q.cnt == CNT_W'(MODE_CYC - 1));
    end

    ims_cost_guard #(
        .COST_W(COST_W),
        .ACC_W (ACC_W)
    ) i_cost_guard (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (start_ok),
        .en_i        (busy),
        .cost_valid_i(cost_valid_i),
        .cost_i      (cost_i),
        .limit_i     (r_q.limit),
        .over_o      (over)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (busy) r_d.cnt = slot_last ? '0 : r_q.cnt + 1'b1;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_V4;
                    r_d.cnt   = '0;
                    r_d.mode  = 4'd0;
                    r_d.blk   = 4'd0;
                    r_d.seen  = 1'b0;
                    r_d.skip  = 1'b0;
                    r_d.limit = best_inter_i;
                end
            end
            ST_V4: begin
                if (slot_last) begin
                    r_d.state = ST_H4;
                    r_d.mode  = 4'd1;
                end
            end
            ST_H4: begin
                if (slot_last) begin
                    r_d.state = ST_NORM;
                    r_d.mode  = 4'd2;
                end
            end
            ST_NORM: begin
                if (slot_last) begin
                    if (r_q.mode == 4'(LAST_MODE4)) begin
                        r_d.state = ST_BEST;
                        r_d.mode  = 4'd0;
                        r_d.seen  = 1'b0;
                    end else begin
                        r_d.mode = r_q.mode + 4'd1;
                    end
                end
            end
            ST_BEST: begin
                if (slot_last) begin
                    r_d.state = ST_SLICE;
                    r_d.mode  = 4'd0;
                end
            end
            ST_SLICE: begin
                r_d.seen = r_q.seen | recon_done_i;
                if (slot_last) begin
                    if (r_q.mode == 4'(N_MODE16 - 1)) begin
                        r_d.mode  = 4'd0;
                        r_d.state = (r_q.blk == BLK_LAST) ? ST_WAIT : ST_VNEXT;
                    end else begin
                        r_d.mode = r_q.mode + 4'd1;
                    end
                end
            end
            ST_VNEXT: begin
                r_d.seen = r_q.seen | recon_done_i;
                if (slot_last) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                r_d.cnt = '0;
                if (r_q.seen || recon_done_i) begin
                    r_d.seen = 1'b0;
                    if (r_q.blk == BLK_LAST) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_H4;
                        r_d.blk   = r_q.blk + 4'd1;
                        r_d.mode  = 4'd1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (over) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.skip  = 1'b1;
            r_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, cnt: '0, mode: '0, blk: '0,
                     seen: 1'b0, skip: 1'b0, done: 1'b0, limit: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_V4, ST_H4, ST_NORM, ST_VNEXT: cat_o = CAT_L4;
            ST_BEST:                         cat_o = CAT_BEST;
            ST_SLICE:                        cat_o = CAT_L16;
            default:                         cat_o = CAT_NONE;
        endcase
    end

    assign issue_valid_o = (cat_o != CAT_NONE);
    assign mode_o        = r_q.mode;
    assign blk_o         = (r_q.state == ST_VNEXT) ? r_q.blk + 4'd1 : r_q.blk;
    assign skip_o        = r_q.skip;
    assign done_o        = r_q.done;

    ims_blk_pos i_blk_pos (
        .idx_i(blk_o),
        .x_o  (blk_x_o),
        .y_o  (blk_y_o)
    );

    ims_dc_store #(
        .DC_W(DC_W)
    ) i_dc_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (dc_valid_i && (cat_o == CAT_L16)),
        .wr_mode_i(mode_o[1:0]),
        .wr_blk_i (blk_o),
        .wr_data_i(dc_i),
        .rd_mode_i(dc_rd_mode_i),
        .rd_blk_i (dc_rd_blk_i),
        .rd_data_o(dc_rd_o)
    );
endmodule

// File: rtl/ims_checker.sv
module ims_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       start_i,
    input logic       issue_valid_o,
    input logic [1:0] cat_o,
    input logic [3:0] mode_o,
    input logic [3:0] blk_o,
    input logic       skip_o,
    input logic       done_o
);
    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_idle_at_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !issue_valid_o);

    assert_skip_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(skip_o) |-> done_o);

    assert_skip_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (skip_o && !start_i) |=> skip_o);

    assert_mode4_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cat_o == 2'd1) |-> (mode_o <= 4'd8));

    assert_mode16_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cat_o == 2'd2) |-> (mode_o <= 4'd3));

    assert_blk_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && $past(issue_valid_o) && (blk_o != $past(blk_o)))
            |-> (blk_o == $past(blk_o) + 4'd1));
endmodule

bind intra_mode_sched ims_checker i_ims_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .issue_valid_o(issue_valid_o),
    .cat_o        (cat_o),
    .mode_o       (mode_o),
    .blk_o        (blk_o),
    .skip_o       (skip_o),
    .done_o       (done_o)
);

// File: tb/test_intra_mode_sched.sv
module test_intra_mode_sched;
    localparam int COST_W = 13;
    localparam int DC_W   = 12;
    localparam int M      = 4;
    localparam int B      = 4;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              start_i = 1'b0;
    logic [COST_W-1:0] best_inter_i = '1;
    logic              cost_valid_i = 1'b0;
    logic [COST_W-1:0] cost_i = '0;
    logic              recon_done_i = 1'b0;
    logic              dc_valid_i = 1'b0;
    logic [DC_W-1:0]   dc_i = '0;
    logic [1:0]        dc_rd_mode_i = '0;
    logic [3:0]        dc_rd_blk_i = '0;
    logic              issue_valid_o;
    logic [1:0]        cat_o;
    logic [3:0]        mode_o, blk_o;
    logic [1:0]        blk_x_o, blk_y_o;
    logic [DC_W-1:0]   dc_rd_o;
    logic              skip_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [1:0] ecat  [0:1023];
    logic [3:0] emode [0:1023];
    logic [3:0] eblk  [0:1023];
    int elen;

    always #2 clk_i = ~clk_i;

    intra_mode_sched #(.MODE_CYC(M), .BEST_CYC(B)) i_intra_mode_sched (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [1:0] c, input logic [3:0] m, input logic [3:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            ecat[elen] = c; emode[elen] = m; eblk[elen] = b; elen++;
        end
    endtask

    task automatic build_sched();
        elen = 0;
        for (int b = 0; b < 16; b++) begin
            if (b == 0) push(2'd1, 4'd0, 4'(b), M);
            for (int m = 1; m <= 8; m++) push(2'd1, 4'(m), 4'(b), M);
            push(2'd3, 4'd0, 4'(b), B);
            for (int m = 0; m < 4; m++) push(2'd2, 4'(m), 4'(b), M);
            if (b < 15) push(2'd1, 4'd0, 4'(b + 1), M);
            push(2'd0, 4'd0, 4'(b), 1);
        end
    endtask

    task automatic do_start(input logic [COST_W-1:0] lim);
        @(negedge clk_i);
        best_inter_i = lim;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    task automatic abort_run();
        cost_valid_i = 1'b1; cost_i = '1;
        @(negedge clk_i);
        @(negedge clk_i);
        cost_valid_i = 1'b0; cost_i = '0;
        @(negedge clk_i);
    endtask

    task automatic t_reset();
        chk(issue_valid_o == 0, "R1 issue idle", issue_valid_o, 0);
        chk(cat_o == 0, "R1 cat idle", cat_o, 0);
        chk(skip_o == 0, "R1 skip", skip_o, 0);
        chk(done_o == 0, "R1 done", done_o, 0);
        cost_valid_i = 1'b1; cost_i = '1;
        repeat (3) @(negedge clk_i);
        cost_valid_i = 1'b0; cost_i = '0;
        chk(skip_o == 0 && done_o == 0, "R1 idle cost ignored", skip_o, 0);
    endtask

    task automatic t_full_run();
        int bad = 0;
        int prev_y = -1, prev_x = -1, prev_b = -1;
        build_sched();
        recon_done_i = 1'b1;
        do_start('1);
        for (int k = 0; k < elen; k++) begin
            if (cat_o != ecat[k] || mode_o != emode[k] || (ecat[k] != 0 && blk_o != eblk[k])) begin
                bad++;
                chk(0, "R3/R4/R5/R6 schedule", {cat_o, mode_o, blk_o},
                    {ecat[k], emode[k], eblk[k]});
            end
            if (cat_o == 2'd1 || cat_o == 2'd2) begin
                chk(blk_x_o == {blk_o[2], blk_o[0]} && blk_y_o == {blk_o[3], blk_o[1]},
                    "R2 position", {blk_y_o, blk_x_o}, {blk_o[3], blk_o[1], blk_o[2], blk_o[0]});
                if (cat_o == 2'd1 && mode_o == 4'd0 && int'(blk_o) != prev_b) begin
                    if (prev_b >= 0)
                        chk(!(blk_x_o == prev_x && (blk_y_o == prev_y + 1)), "R2 not vertical neighbour",
                            blk_o, prev_b);
                    prev_b = blk_o; prev_x = blk_x_o; prev_y = blk_y_o;
                end
            end
            dc_valid_i = (cat_o == 2'd2);
            dc_i = DC_W'(12'h100 + mode_o * 16 + blk_o);
            chk(done_o == 0, "R7 no early done", done_o, 0);
            @(negedge clk_i);
        end
        dc_valid_i = 1'b0;
        chk(done_o == 1, "R7 done at 912", done_o, 1);
        chk(elen == 912, "R7 cycle budget", elen, 912);
        chk(skip_o == 0, "R8 no skip", skip_o, 0);
        chk(bad == 0, "R3 sequence total", bad, 0);
        @(negedge clk_i);
        chk(done_o == 0, "R7 done one cycle", done_o, 0);
        recon_done_i = 1'b0;
        for (int md = 0; md < 4; md++) begin
            for (int b = 0; b < 16; b++) begin
                dc_rd_mode_i = 2'(md); dc_rd_blk_i = 4'(b);
                #1;
                chk(dc_rd_o == DC_W'(12'h100 + md * 16 + b), "R12 dc store", dc_rd_o, 12'h100 + md * 16 + b);
            end
        end
    endtask

    task automatic t_recon_wait();
        bit early_v = 0;
        int guard = 0;
        recon_done_i = 1'b0;
        do_start('1);
        while (!(cat_o == 2'd0) && guard < 200) begin
            if (cat_o == 2'd1 && mode_o == 4'd0 && blk_o == 4'd1) early_v = 1;
            @(negedge clk_i); guard++;
        end
        chk(early_v, "R5 early vertical of block 1", early_v, 1);
        for (int i = 0; i < 10; i++) begin
            chk(issue_valid_o == 0, "R6 stall without recon", issue_valid_o, 0);
            @(negedge clk_i);
        end
        recon_done_i = 1'b1;
        @(negedge clk_i);
        recon_done_i = 1'b0;
        chk(cat_o == 2'd1 && mode_o == 4'd1 && blk_o == 4'd1, "R6 resume horizontal",
            {cat_o, mode_o, blk_o}, {2'd1, 4'd1, 4'd1});
        guard = 0;
        while (cat_o != 2'd2 && guard < 200) begin @(negedge clk_i); guard++; end
        recon_done_i = 1'b1;
        @(negedge clk_i);
        recon_done_i = 1'b0;
        guard = 0;
        while (cat_o != 2'd0 && guard < 200) begin @(negedge clk_i); guard++; end
        @(negedge clk_i);
        chk(cat_o == 2'd1 && mode_o == 4'd1 && blk_o == 4'd2, "R6 early recon remembered",
            {cat_o, mode_o, blk_o}, {2'd1, 4'd1, 4'd2});
        abort_run();
    endtask

    task automatic t_skip();
        do_start(13'd90);
        for (int i = 0; i < 3; i++) begin
            cost_valid_i = 1'b1; cost_i = 13'd30;
            @(negedge clk_i);
            cost_valid_i = 1'b0;
            chk(done_o == 0 && skip_o == 0, "R8 total equal limit no abort", skip_o, 0);
        end
        cost_valid_i = 1'b1; cost_i = 13'd1;
        @(negedge clk_i);
        cost_valid_i = 1'b0; cost_i = '0;
        chk(done_o == 1 && skip_o == 1, "R8 abort edge", {done_o, skip_o}, 3);
        chk(issue_valid_o == 0, "R8 issue stops", issue_valid_o, 0);
        @(negedge clk_i);
        chk(done_o == 0, "R8 done pulse", done_o, 0);
        repeat (5) @(negedge clk_i);
        chk(skip_o == 1 && issue_valid_o == 0, "R11 skip held", skip_o, 1);
    endtask

    task automatic t_clear_and_latch();
        do_start(13'd90);
        chk(skip_o == 0, "R9 skip cleared at start", skip_o, 1'b0);
        best_inter_i = '0;
        cost_valid_i = 1'b1; cost_i = 13'd60;
        @(negedge clk_i);
        cost_valid_i = 1'b0;
        chk(skip_o == 0 && issue_valid_o == 1, "R9 total cleared and limit latched", skip_o, 0);
        cost_valid_i = 1'b1; cost_i = 13'd31;
        @(negedge clk_i);
        cost_valid_i = 1'b0; cost_i = '0;
        chk(skip_o == 1, "R9 latched limit abort", skip_o, 1);
        best_inter_i = '1;
        @(negedge clk_i);
    endtask

    task automatic t_start_busy();
        recon_done_i = 1'b1;
        do_start('1);
        repeat (5) @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        chk(cat_o == 2'd1 && mode_o == 4'd2 && blk_o == 4'd0, "R10 start ignored while busy",
            {cat_o, mode_o}, {2'd1, 4'd2});
        abort_run();
        recon_done_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_full_run();
        t_recon_wait();
        t_skip();
        t_clear_and_latch();
        t_start_busy();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule